// File: doc/BRIEF.md
# Edge-Selectable Interrupt Latch Controller

This block gathers 32 peripheral interrupt lines and turns them into two latched interrupt groups. Each line has its own rising-edge enable and falling-edge enable. With these a line can latch on a low-to-high transition, a high-to-low transition, either one, or nothing. The line inputs are asynchronous, so they pass through a synchronizer before edge detection. A second set of 32 synchronous event inputs carries single-cycle pulses, such as transfer-done or buffer-full. These pulses are latched directly and need no enable.

A priority-select register steers each line to the high or the low group. Each group has a latch register that clears itself when it is read. If an edge arrives in the same cycle as the clearing read, that bit stays set afterwards, so the interrupt is not lost. Each group drives one registered summary interrupt, which is high while any bit of its latch register is set. Software reaches all the registers through a simple read/write bus. Read data appears one cycle after the read strobe.

Top module: `irq_edge_latch_ctrl`

## Requirements
- R1: With bit i of the rising-enable register (address 0) set, a 0-to-1 transition on line_in[i] sets latch bit i.
- R2: With bit i of the falling-enable register (address 1) set, a 1-to-0 transition on line_in[i] sets latch bit i.
- R3: With both enables set, either transition latches. With neither set, no transition on that line latches anything.
- R4: A high evt_in[i] at a clock edge sets latch bit i whatever the edge enables hold.
- R5: Priority-select (address 2) bit i = 1 steers line i to the high latch (address 3). Bit i = 0 steers it to the low latch (address 4).
- R6: A read of address 4 returns the low latch contents on the next cycle and clears every low latch bit in the same access.
- R7: A read of address 3 returns the high latch contents on the next cycle and clears every high latch bit in the same access.
- R8: A latch event in the same cycle as its group's clearing read leaves that bit set after the read.
- R9: irq_hi_o / irq_lo_o are high in exactly the cycles in which the high / low latch is nonzero.
- R10: After reset, all enables, the priority select, both latches, both summaries and bus_rdata are zero.
- R11: Writes to addresses 3 and 4 have no effect. Reads of addresses 5 to 7 return zero.
- R12: A line input change at a clock edge is detected two edges later, through a two-stage synchronizer. The latch bit is set at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 32 | Asynchronous waveform interrupt lines |
| evt_in | input | 32 | Synchronous single-cycle event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_hi_o | output | 1 | High-group summary interrupt |
| irq_lo_o | output | 1 | Low-group summary interrupt |

## Verification
The bench sweeps a line edge across the cycles around a clearing read. A design that let the clear win would drop that interrupt. It toggles lines whose enables are off and checks that a design with a leaky enable mask would latch a bit there. It changes the priority select and the enables between events, so that a design that steered on the wrong edge or used stale enables would put bits in the wrong group. It writes to the latch addresses, where a design that lacked write protection would corrupt a pending interrupt.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_RISE_EN = 3'd0,
    REG_FALL_EN = 3'd1,
    REG_PRIO    = 3'd2,
    REG_LATCH_H = 3'd3,
    REG_LATCH_L = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][N-1:0] chain_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], line_in};
      prev_q  <= chain_q[LAST];
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_edge
      assign rise[i] = chain_q[LAST][i] & ~prev_q[i];
      assign fall[i] = ~chain_q[LAST][i] & prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/irq_latch_group.sv
module irq_latch_group #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         rd_clr,
  output logic [N-1:0] latch_q,
  output logic         summary_q
);
  logic [N-1:0] latch_nxt;

  // A clear takes out the old contents. A set in the same cycle still lands.
  assign latch_nxt = (rd_clr ? '0 : latch_q) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      summary_q <= 1'b0;
    end else begin
      latch_q   <= latch_nxt;
      summary_q <= |latch_nxt;
    end
  end
endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_latch_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  input  logic [N-1:0]      latch_hi,
  input  logic [N-1:0]      latch_lo,
  output logic [N-1:0]      rise_en_q,
  output logic [N-1:0]      fall_en_q,
  output logic [N-1:0]      prio_q,
  output logic [N-1:0]      rdata_q,
  output logic              clr_hi,
  output logic              clr_lo
);
  logic [N-1:0] rd_mux;

  always_comb begin
    case (bus_addr)
      REG_RISE_EN: rd_mux = rise_en_q;
      REG_FALL_EN: rd_mux = fall_en_q;
      REG_PRIO:    rd_mux = prio_q;
      REG_LATCH_H: rd_mux = latch_hi;
      REG_LATCH_L: rd_mux = latch_lo;
      default:     rd_mux = '0;
    endcase
  end

  assign clr_hi = bus_rd && (bus_addr == REG_LATCH_H);
  assign clr_lo = bus_rd && (bus_addr == REG_LATCH_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      prio_q    <= '0;
      rdata_q   <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          REG_RISE_EN: rise_en_q <= bus_wdata;
          REG_FALL_EN: fall_en_q <= bus_wdata;
          REG_PRIO:    prio_q    <= bus_wdata;
          default:     ;
        endcase
      end
      if (bus_rd) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_edge_latch_ctrl.sv
module irq_edge_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] evt_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 irq_hi_o,
  output logic                 irq_lo_o
);
  logic [NUM_LINES-1:0] rise, fall, hit;
  logic [NUM_LINES-1:0] rise_en_q, fall_en_q, prio_q;
  logic [NUM_LINES-1:0] latch_hi_q, latch_lo_q, set_hi, set_lo;
  logic                 clr_hi, clr_lo;

  irq_edge_detect #(.N(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .line_in(line_in), .rise(rise), .fall(fall)
  );

  irq_csr_regs #(.N(NUM_LINES)) u_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .latch_hi(latch_hi_q), .latch_lo(latch_lo_q),
    .rise_en_q(rise_en_q), .fall_en_q(fall_en_q), .prio_q(prio_q),
    .rdata_q(bus_rdata), .clr_hi(clr_hi), .clr_lo(clr_lo)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign hit[i]    = (rise[i] & rise_en_q[i]) | (fall[i] & fall_en_q[i]) | evt_in[i];
      assign set_hi[i] = hit[i] & prio_q[i];
      assign set_lo[i] = hit[i] & ~prio_q[i];
    end
  endgenerate

  irq_latch_group #(.N(NUM_LINES)) u_grp_hi (
    .clk(clk), .rst(rst), .set_vec(set_hi), .rd_clr(clr_hi),
    .latch_q(latch_hi_q), .summary_q(irq_hi_o)
  );

  irq_latch_group #(.N(NUM_LINES)) u_grp_lo (
    .clk(clk), .rst(rst), .set_vec(set_lo), .rd_clr(clr_lo),
    .latch_q(latch_lo_q), .summary_q(irq_lo_o)
  );
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
  import irq_latch_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N-1:0]      bus_rdata,
  input logic [N-1:0]      latch_hi,
  input logic [N-1:0]      latch_lo,
  input logic [N-1:0]      set_lo,
  input logic              irq_hi_o,
  input logic              irq_lo_o
);
  // R6
  lo_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_LATCH_L) |=> (latch_lo == $past(set_lo)));

  // R7
  hi_read_data_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_LATCH_H) |=> (bus_rdata == $past(latch_hi)));

  // R7
  hi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == REG_LATCH_H) |=> ((latch_hi & $past(latch_hi)) == $past(latch_hi)));

  // R9
  hi_summary_chk: assert property (@(posedge clk) disable iff (rst)
    irq_hi_o == (latch_hi != '0));

  // R9
  lo_summary_chk: assert property (@(posedge clk) disable iff (rst)
    irq_lo_o == (latch_lo != '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (latch_hi == '0 && latch_lo == '0 && bus_rdata == '0));
endmodule

bind irq_edge_latch_ctrl irq_latch_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .latch_hi(latch_hi_q), .latch_lo(latch_lo_q),
  .set_lo(set_lo), .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
);

// File: tb/tb_irq_edge_latch_ctrl.sv
`timescale 1ns/1ps
module tb_irq_edge_latch_ctrl;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  line_in = '0, evt_in = '0, bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_hi_o, irq_lo_o;

  int   tests = 0, fails = 0, cycles = 0;
  bit   done = 1'b0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  irq_edge_latch_ctrl dut (
    .clk(clk), .rst(rst), .line_in(line_in), .evt_in(evt_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
  );

  // Reference model: an input history queue, the registers, and read-clear.
  logic [N-1:0] hist[$];
  logic [N-1:0] m_ren, m_fen, m_prio, m_hi, m_lo, m_rdata;
  logic         m_irq_hi, m_irq_lo;

  function automatic void model_reset();
    hist = {'0, '0, '0};
    m_ren = '0; m_fen = '0; m_prio = '0; m_hi = '0; m_lo = '0; m_rdata = '0;
    m_irq_hi = 1'b0; m_irq_lo = 1'b0;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      logic [N-1:0] now, old, ev, new_hi, new_lo;
      now = hist[1];          // sample taken two edges ago
      old = hist[2];          // sample taken three edges ago
      ev  = (now & ~old & m_ren) | (~now & old & m_fen) | evt_in;
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata = m_ren;
          3'd1: m_rdata = m_fen;
          3'd2: m_rdata = m_prio;
          3'd3: m_rdata = m_hi;
          3'd4: m_rdata = m_lo;
          default: m_rdata = '0;
        endcase
      end
      new_hi = ((bus_rd && bus_addr == 3'd3) ? '0 : m_hi) | (ev & m_prio);
      new_lo = ((bus_rd && bus_addr == 3'd4) ? '0 : m_lo) | (ev & ~m_prio);
      m_hi = new_hi; m_lo = new_lo;
      m_irq_hi = (m_hi != 0); m_irq_lo = (m_lo != 0);
      if (bus_wr) begin
        if (bus_addr == 3'd0) m_ren = bus_wdata;
        if (bus_addr == 3'd1) m_fen = bus_wdata;
        if (bus_addr == 3'd2) m_prio = bus_wdata;
      end
      hist.push_front(line_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst || cur_req == "R10") begin
      tests++;
      if (bus_rdata !== m_rdata || irq_hi_o !== m_irq_hi || irq_lo_o !== m_irq_lo) begin
        fails++;
        $display("FAIL %s: rdata=%h hi=%b lo=%b expected rdata=%h hi=%b lo=%b",
                 cur_req, bus_rdata, irq_hi_o, irq_lo_o, m_rdata, m_irq_hi, m_irq_lo);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic drain();
    idle(4); rd(3'd3); rd(3'd4); idle(2);
  endtask

  initial begin
    cur_req = "R10";
    idle(4); rst = 1'b0;
    for (int a = 0; a < 5; a++) rd(a[2:0]);
    idle(2);

    cur_req = "R12";
    line_in = 32'h0000_0001; idle(1);   // no enables yet: must not latch
    line_in = '0; idle(5);

    cur_req = "R1";
    wr(3'd0, 32'h0000_00FF);
    line_in = 32'h0000_000F; idle(5); rd(3'd4);
    line_in = '0; idle(5); rd(3'd4); idle(2);

    cur_req = "R2";
    wr(3'd0, '0); wr(3'd1, 32'h0000_FF00);
    line_in = 32'h0000_FFFF; idle(5); rd(3'd4);
    line_in = '0; idle(5); rd(3'd4); idle(2);

    cur_req = "R3";
    wr(3'd0, 32'h00FF_0000); wr(3'd1, 32'h00FF_0000);
    line_in = 32'hFFFF_0000; idle(5); rd(3'd4); rd(3'd4);
    line_in = 32'h00AA_0000; idle(5); rd(3'd4);
    line_in = '0; drain();

    cur_req = "R5";
    wr(3'd2, 32'hF0F0_F0F0); wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, '0);
    line_in = 32'h3C3C_3C3C; idle(5); rd(3'd3); rd(3'd4);
    wr(3'd2, 32'h0F0F_0F0F);
    line_in = 32'hFFFF_FFFF; idle(5); rd(3'd3); rd(3'd4);
    line_in = '0; drain();

    cur_req = "R4";
    wr(3'd0, '0); wr(3'd1, '0);
    @(negedge clk); evt_in = 32'h8000_0001;
    @(negedge clk); evt_in = '0;
    idle(2); rd(3'd3); rd(3'd4); idle(2);

    cur_req = "R6";
    @(negedge clk); evt_in = 32'h0000_0100;
    @(negedge clk); evt_in = '0;
    rd(3'd4); rd(3'd4); idle(2);

    cur_req = "R7";
    @(negedge clk); evt_in = 32'h0100_0000;
    @(negedge clk); evt_in = '0;
    rd(3'd3); rd(3'd3); idle(2);

    cur_req = "R8";
    @(negedge clk); evt_in = 32'h0001_0002; bus_rd = 1'b1; bus_addr = 3'd4;
    @(negedge clk); evt_in = '0; bus_rd = 1'b0;
    rd(3'd4);
    wr(3'd0, 32'h0000_0404);
    for (int d = 0; d < 5; d++) begin
      line_in = 32'h0000_0404; idle(d); rd(3'd3); rd(3'd4);
      idle(3); rd(3'd3); rd(3'd4);
      line_in = '0; idle(4);
    end
    drain();

    cur_req = "R11";
    @(negedge clk); evt_in = 32'h0000_0011;
    @(negedge clk); evt_in = '0;
    wr(3'd3, '0); wr(3'd4, 32'hFFFF_FFFF);
    for (int a = 5; a < 8; a++) rd(a[2:0]);
    rd(3'd3); rd(3'd4);

    cur_req = "R9";
    @(negedge clk); evt_in = 32'hFFFF_FFFF;
    @(negedge clk); evt_in = '0;
    idle(2); rd(3'd3); idle(2); rd(3'd4); idle(2);

    cur_req = "R10";
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    for (int a = 0; a < 5; a++) rd(a[2:0]);
    idle(2);
    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule